// File: doc/BRIEF.md
# Reloadable Modulo Delay Counter

This block produces a one-clock terminal pulse at a fixed interval of enabled clocks. It is meant for long programmable delays and rate dividers where a wide magnitude comparator between the count and a target value would be slow or costly. The default build is a down-counter with one extra sign bit. It starts from the load value and steps down by one on each enabled clock. Terminal count is the moment the sign bit sets, which happens when the counter passes below zero. On the next enabled edge it restarts from the load input. The interval therefore follows the load value directly: a load value of L gives a period of L+2 enabled clocks, so a period of N needs a load of N-2. A period of ten million fits in the 24-bit default.

A build-time option replaces this with a fixed-modulus up-counter. It runs from zero towards a constant end value and recognises that value by testing only the bit positions that are 1 in it. This is sound because the count never goes past the end value: the first value that has all of those bits set is the end value itself. In this variant the load input has no effect.

Top module: `modcnt_top`

## Requirements
- R1: While rst_n is low at a clock edge, the counter loads: count becomes ld_val in down mode and zero in fixed mode, and tick is low.
- R2: In down mode, each enabled clock with tick low lowers count by one.
- R3: In down mode, tick is high for exactly one enabled clock, the one in which the counter is below zero, and count then reads all ones. With a constant load value L, tick repeats every L+2 enabled clocks.
- R4: In down mode, the enabled edge that ends a tick cycle reloads count with the value on ld_val at that edge. Changes to ld_val at other times do not alter the period that is running.
- R5: With en low at a clock edge (rst_n high), neither count nor tick changes at that edge, in either mode.
- R6: Load value 0 gives a tick every second enabled clock, and load value 1 gives a tick every third enabled clock.
- R7: In fixed mode (MODE = MODE_FIXED), count starts at 0 and rises by one per enabled clock. tick is high while count equals END_VAL, which is decoded from its 1-bits only. The edge after that returns count to 0, so the period is END_VAL+1 enabled clocks. ld_val has no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count enable; low freezes the counter |
| ld_val | input | WIDTH | Down-mode start and reload value (period = ld_val + 2) |
| count | output | WIDTH | Current count value (all ones while below zero in down mode) |
| tick | output | 1 | Terminal pulse |

## Verification
count and tick come straight from the counter register. A change on en or ld_val made before rising edge k therefore shows at the outputs after edge k and not before; the reload picks up ld_val as it stands at that same edge. In fixed mode tick is decoded from the registered count, so it is valid in the same cycle as that count. The bench changes inputs on the falling edge, advances its reference model on the rising edge, and compares both outputs on the next falling edge. Each check therefore sees exactly one edge's worth of effect from the stimulus.

// File: rtl/modcnt_pkg.sv
// Package: shared types for the reloadable modulo delay counter.
// Assumes nothing beyond IEEE 1800-2017.
package modcnt_pkg;

    // Selects which counter variant the top builds.
    typedef enum logic {
        MODE_DOWN  = 1'b0,  // sign-detect down-counter with reload
        MODE_FIXED = 1'b1   // fixed-end up-counter with sparse decode
    } mode_e;

endpackage

// File: rtl/modcnt_down.sv
// Module: modcnt_down
// Down-counter with one guard (sign) bit. Starts at ld_val, steps down by
// one per enabled clock, and flags terminal count when the sign bit sets.
// No comparator against a target is used. The enabled edge after the
// terminal cycle reloads from ld_val, so the period is ld_val + 2.
// Assumes: synchronous active-low reset; ld_val held by the driver.
module modcnt_down #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] count,
    output logic             tick
);
    localparam int          CW      = WIDTH + 1;
    localparam logic [CW-1:0] STEP  = {{WIDTH{1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] start_val;
    logic          below_zero;

    // Zero-extend the load value into the guarded counter width.
    assign start_val  = {1'b0, ld_val};
    assign below_zero = cnt_q[CW-1];

    // Counter register: load on reset, reload after terminal, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= start_val;
        end else if (en) begin
            if (below_zero) begin
                cnt_q <= start_val;
            end else begin
                cnt_q <= cnt_q - STEP;
            end
        end
    end

    // Outputs: low bits as the count, guard bit as the terminal pulse.
    assign count = cnt_q[WIDTH-1:0];
    assign tick  = below_zero;

endmodule

// File: rtl/modcnt_sparse.sv
// Module: modcnt_sparse
// Fixed-modulus up-counter. Counts from 0 and recognises END_VAL by looking
// only at the bit positions that are 1 in END_VAL; valid because the count
// never exceeds END_VAL. Wraps to 0 on the enabled edge after the match.
// Assumes: WIDTH >= 2, END_VAL nonzero.
module modcnt_sparse #(
    parameter int               WIDTH   = 24,
    parameter logic [WIDTH-1:0] END_VAL = 24'h989680
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] count,
    output logic             tick
);
    localparam logic [WIDTH-1:0] CARE = END_VAL;
    localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] cnt_q;
    logic             at_end;

    // Sparse decode: every cared-for bit must be 1, others are don't-care.
    assign at_end = &(cnt_q | ~CARE);

    // Counter register: clear on reset, wrap after the end value, else step up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            if (at_end) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + STEP;
            end
        end
    end

    assign count = cnt_q;
    assign tick  = at_end;

endmodule

// File: rtl/modcnt_top.sv
// Module: modcnt_top
// Reloadable modulo delay counter. MODE picks the sign-detect down-counter
// (period ld_val + 2) or the fixed-end up-counter (period END_VAL + 1).
// Assumes: synchronous active-low reset; single clock domain.
module modcnt_top
    import modcnt_pkg::*;
#(
    parameter int               WIDTH   = 24,
    parameter mode_e            MODE    = MODE_DOWN,
    parameter logic [WIDTH-1:0] END_VAL = 24'h989680
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] count,
    output logic             tick
);

    // Variant selection at elaboration time.
    generate
        if (MODE == MODE_FIXED) begin : g_fixed
            logic unused_ld;
            assign unused_ld = ^ld_val;

            modcnt_sparse #(
                .WIDTH   (WIDTH),
                .END_VAL (END_VAL)
            ) u_sparse (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en),
                .count (count),
                .tick  (tick)
            );
        end else begin : g_down
            modcnt_down #(
                .WIDTH (WIDTH)
            ) u_down (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (en),
                .ld_val (ld_val),
                .count  (count),
                .tick   (tick)
            );
        end
    endgenerate

endmodule

// File: rtl/modcnt_chk.sv
// Module: modcnt_chk
// Property checker for modcnt_top, attached by bind. Watches ports only.
// Assumes: synchronous active-low reset on rst_n.
module modcnt_chk
    import modcnt_pkg::*;
#(
    parameter int               WIDTH   = 24,
    parameter mode_e            MODE    = MODE_DOWN,
    parameter logic [WIDTH-1:0] END_VAL = 24'h989680
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [WIDTH-1:0] ld_val,
    input logic [WIDTH-1:0] count,
    input logic             tick
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic live_q;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R5: disabled edges change nothing.
    a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        !en |=> ($stable(count) && $stable(tick)));

    generate
        if (MODE == MODE_FIXED) begin : g_fixed_chk
            // R7: wrap to zero after the end value.
            a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                (en && tick) |=> (count == '0));
            // R7: step up by one before the end value.
            a_r7_step: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                (en && !tick) |=> (count == $past(count) + ONE));
            // R7: the pulse only ever marks the full end value.
            a_r7_end_only: assert property (@(posedge clk) disable iff (!rst_n)
                tick |-> (count == END_VAL));
        end else begin : g_down_chk
            // R2: step down by one outside the terminal cycle.
            a_r2_step: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                (en && !tick) |=> (count == $past(count) - ONE));
            // R3: pulse lasts one enabled clock.
            a_r3_single: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                (en && tick) |=> !tick);
            // R3: count reads all ones during the pulse.
            a_r3_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
                tick |-> (&count));
            // R4: reload takes the load value present at the reload edge.
            a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
                (en && tick) |=> (count == $past(ld_val)));
        end
    endgenerate

endmodule

bind modcnt_top modcnt_chk #(
    .WIDTH   (WIDTH),
    .MODE    (MODE),
    .END_VAL (END_VAL)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .ld_val (ld_val),
    .count  (count),
    .tick   (tick)
);

// File: tb/modcnt_top_tb_top.sv
// Bench for modcnt_top: one down-mode instance (default width) and one
// fixed-mode instance with a short end value. Reference models follow the
// requirements; outputs are compared on every falling edge.
module modcnt_top_tb_top;
    import modcnt_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          DW         = 24;
    localparam int          FW         = 12;
    localparam logic [FW-1:0] FEND     = 12'h0B4;  // 180: bits 7,5,4,2
    localparam int          WDOG_MAX   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [DW-1:0] ld = 24'd12;
    logic [FW-1:0] ld_fix = '0;
    logic [DW-1:0] d_count;
    logic          d_tick;
    logic [FW-1:0] f_count;
    logic          f_tick;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    string tag      = "R1";

    // Reference state: down model carries a sign bit, fixed model plain.
    logic [DW:0]   m_dn;
    logic [FW-1:0] m_fx;

    always #(CLK_PERIOD/2) clk = ~clk;

    modcnt_top #(.WIDTH(DW), .MODE(MODE_DOWN)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .ld_val(ld),
        .count(d_count), .tick(d_tick)
    );

    modcnt_top #(.WIDTH(FW), .MODE(MODE_FIXED), .END_VAL(FEND)) dut_fix_i (
        .clk(clk), .rst_n(rst_n), .en(en), .ld_val(ld_fix),
        .count(f_count), .tick(f_tick)
    );

    // Reference models advance on the rising edge from the stable inputs.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_dn <= {1'b0, ld};
            m_fx <= '0;
        end else if (en) begin
            m_dn <= m_dn[DW] ? {1'b0, ld} : (m_dn - 25'd1);
            m_fx <= (m_fx == FEND) ? '0 : (m_fx + 12'd1);
        end
    end

    task automatic chk(input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    // One cycle: compare at the falling edge, then drive new inputs.
    task automatic step(input logic e, input logic [DW-1:0] l, input logic [FW-1:0] lf);
        @(negedge clk);
        chk(tag, "down count", 32'(d_count), 32'(m_dn[DW-1:0]));
        chk(tag, "down tick",  32'(d_tick),  32'(m_dn[DW]));
        chk((tag == "R1") ? "R1" : "R7", "fixed count", 32'(f_count), 32'(m_fx));
        chk((tag == "R1") ? "R1" : "R7", "fixed tick",  32'(f_tick),  32'(m_fx == FEND));
        en     = e;
        ld     = l;
        ld_fix = lf;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > WDOG_MAX) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG_MAX);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int tick_seen;
        void'($urandom(32'd20240611));

        // R1: reset loads the start values, no pulse.
        tag = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(1'b1, 24'd12, 12'h3FF);
        @(negedge clk);
        chk("R1", "down count in reset", 32'(d_count), 32'd12);
        chk("R1", "tick in reset", 32'(d_tick | f_tick), 32'd0);
        rst_n = 1'b1;

        // R2: steady decrement from a constant load.
        tag = "R2";
        for (int i = 0; i < 40; i++) step(1'b1, 24'd12, 12'(i));

        // R3: one-cycle pulse every L+2 enabled clocks; count pulses directly.
        tag = "R3";
        tick_seen = 0;
        for (int i = 0; i < 90; i++) begin
            step(1'b1, 24'd7, '0);
            tick_seen += int'(d_tick);
        end
        chk("R3", "pulses in 90 clocks at period 9", 32'(tick_seen), 32'd10);

        // R4: load value changes mid-count, random timing.
        tag = "R4";
        for (int i = 0; i < 300; i++) begin
            logic [DW-1:0] l;
            l = ((i % 7) == 3) ? DW'($urandom_range(0, 20)) : ld;
            step(1'b1, l, FW'($urandom));
        end

        // R5: random enable freezes and resumes.
        tag = "R5";
        for (int i = 0; i < 800; i++) begin
            logic [DW-1:0] l;
            l = ((i % 50) == 0) ? DW'($urandom_range(0, 30)) : ld;
            step(1'($urandom_range(0, 1)), l, FW'($urandom));
        end

        // R6: smallest load values.
        tag = "R6";
        for (int i = 0; i < 50; i++) step(1'b1, 24'd0, '0);
        for (int i = 0; i < 50; i++) step(1'b1, 24'd1, '0);

        // R1: reset in mid-run with a new load value.
        tag = "R1";
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b0, 24'd5, '0);
        rst_n = 1'b1;

        // R7: long enabled run for several fixed-mode wraps, ld_val random.
        tag = "R7";
        for (int i = 0; i < 700; i++) begin
            step(($urandom_range(0, 9) != 0), DW'($urandom_range(0, 40)), FW'($urandom));
        end

        // Large load value, deep down-count.
        tag = "R2";
        for (int i = 0; i < 200; i++) step(1'b1, 24'd9999998, '0);

        step(1'b1, 24'd3, '0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule